// File: doc/BRIEF.md
# MAC Address Hash Filter

This block decides whether a received frame's destination MAC address is wanted. It keeps a 2048-entry table of 64-bit entries. A 48-bit address is folded into an 11-bit home index, and a bounded run of consecutive entries starting there is searched. The table is open-addressed: an address that collides with an occupied home slot is placed in the next free slot. The search wraps from the last index back to index 0.

One request port serves three operations: lookup, add and delete. Each operation runs through a single sequential controller that reads one table entry per clock. The controller returns a one-cycle completion pulse with the result. A lookup reports accept or reject and the destination flag stored with the matching entry. An add reports where the entry was placed, or that the search window was full. A delete reports whether a matching entry was removed.

After reset, the controller sweeps the whole table to the empty state before it accepts any request. Each entry holds a valid flag in bit 0, a skip flag in bit 1 and a destination flag in bit 2. The address sits above these flags. Matching compares every bit above the three flag bits.

Top module: `mac_hash_filter`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 2048 clock cycles while the table is cleared, and `done` stays low. After the sweep, every lookup misses.
- R2: Let byte 0 of `req_mac` be [47:40]. The low part L is `req_mac[31:0]` and the high part H is `req_mac[47:32]`, each with the bits of every byte reversed. The home index is {L[3:2], {L[14:8],L[1:0]} ^ L[23:15] ^ {H[0],L[31:24]}}. A lookup in an empty table reports this index on `slot`.
- R3: A lookup that finds a valid entry with the same address and a clear skip flag completes with `hit`=1. In that case `hit_dest` equals the destination flag that was stored by the add.
- R4: A lookup that finds its address in an entry whose skip flag is set completes with `hit`=0 and `hit_dest`=0.
- R5: A lookup stops at the first invalid entry in its window and rejects. A lookup that examines HOPS (default 12) valid non-matching entries also rejects.
- R6: An add writes the first entry in its window that is either invalid or already holds the same address, whichever comes first. It reports `hit`=1 and the index on `slot`. Re-adding a present address updates its flags in place.
- R7: The probe index increments by one per examined entry and wraps from 2047 to 0.
- R8: An add that finds neither a free nor a matching entry within HOPS entries completes with `full`=1 and `hit`=0, and leaves the table unchanged.
- R9: A delete of a present address invalidates that entry and reports `hit`=1. A delete of an absent address reports `hit`=0.
- R10: A request raised while `busy` is high is ignored. It produces no completion and does not change the table.
- R11: `done` is high for exactly one cycle, p+1 cycles after the accepting edge, where p is the number of entries examined. The result outputs hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 2 | 0 lookup, 1 add, 2 delete, 3 acts as lookup |
| req_mac | input | 48 | Destination address, byte 0 in [47:40] |
| req_skip | input | 1 | Skip flag written by an add |
| req_dest | input | 1 | Destination flag written by an add |
| busy | output | 1 | Clearing or operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Accept / placed / removed |
| hit_dest | output | 1 | Destination flag of an accepting lookup |
| full | output | 1 | Add found no room in its window |
| slot | output | 11 | Index where the operation ended |

## Verification
Two events can fall in the same cycle: a completion is delivered, and the next request is accepted. The controller returns to idle on the edge that raises `done`, so the host may present its next request during that pulse. The bench does exactly that. It checks that the first result stays on the outputs while the second operation runs, and that the second result is correct and arrives on time. A separate case raises a request in the middle of a long probe. It is judged by counting completions and then looking up the address that the ignored request would have added.

// File: rtl/mhf_pkg.sv
// Package: shared types and constants of the MAC hash filter.
// Assumes: the index width is fixed at 11 by the hash definition.
package mhf_pkg;
    localparam int IDX_W = 11;
    localparam int MAC_W = 48;
    localparam int FLAG_W = 3;
    localparam int VALID_B = 0;
    localparam int SKIP_B = 1;
    localparam int DEST_B = 2;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_ADD    = 2'd1,
        OP_DELETE = 2'd2,
        OP_SPARE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PROBE = 2'd2
    } state_e;
endpackage

// File: rtl/mhf_hash.sv
// Module: mhf_hash
// Folds a destination address into the 11-bit home index. Each byte is
// bit-reversed, and three 9-bit slices are XOR-folded under two index bits.
// Assumes: only bit 0 of the transformed high part matters, so only the
// address bit that lands there is brought in.
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [31:0]      key_lo,
    input  logic             key_hi_bit,
    output logic [IDX_W-1:0] home_idx
);
    logic [31:0] lo_rev;
    logic [8:0]  fold;

    // Reverse the bit order inside every byte of the low part.
    for (genvar b = 0; b < 4; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign lo_rev[8*b + i] = key_lo[8*b + 7 - i];
        end
    end

    // XOR three slices of the transformed low word with the high bit on top.
    always_comb begin
        fold     = {lo_rev[14:8], lo_rev[1:0]} ^ lo_rev[23:15] ^ {key_hi_bit, lo_rev[31:24]};
        home_idx = {lo_rev[3:2], fold};
    end
endmodule

// File: rtl/mhf_table.sv
// Module: mhf_table
// Single-port entry store: one synchronous write and one combinational read
// at the same address per cycle.
// Assumes: no reset of contents; the controller sweeps it empty.
module mhf_table
    import mhf_pkg::*;
#(
    parameter int ENTRY_W = 64
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   addr,
    input  logic [ENTRY_W-1:0] wdata,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Write one entry when the controller asks for it.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/mhf_ctrl.sv
// Module: mhf_ctrl
// Sequential prober. It clears the table after reset, then serves lookup,
// add and delete requests, examining one entry per clock from the home
// index for at most HOPS entries.
// Assumes: requests are taken only in the idle state; rd_data is the entry
// at tbl_addr in the same cycle.
module mhf_ctrl
    import mhf_pkg::*;
#(
    parameter int HOPS    = 12,
    parameter int ENTRY_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [MAC_W-1:0]   req_mac,
    input  logic               req_skip,
    input  logic               req_dest,
    input  logic [IDX_W-1:0]   home_idx,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic               tbl_we,
    output logic [IDX_W-1:0]   tbl_addr,
    output logic [ENTRY_W-1:0] tbl_wdata,
    output logic               busy,
    output logic               done,
    output logic               hit,
    output logic               hit_dest,
    output logic               full,
    output logic [IDX_W-1:0]   slot
);
    localparam int HW  = $clog2(HOPS + 1);
    localparam int PAD = ENTRY_W - FLAG_W - MAC_W;
    localparam logic [HW-1:0] LAST_HOP = HW'(HOPS - 1);

    state_e           state;
    op_e              op_q;
    logic [MAC_W-1:0] key_q;
    logic             skip_q, dest_q;
    logic [IDX_W-1:0] ptr;
    logic [HW-1:0]    hops;

    logic match, empty, last, fin, res_hit, res_full, res_dest;

    // Classify the entry under the pointer.
    always_comb begin
        empty = !rd_data[VALID_B];
        match = rd_data[VALID_B] &&
                (rd_data[ENTRY_W-1:FLAG_W] == {{PAD{1'b0}}, key_q});
        last  = (hops == LAST_HOP);
    end

    // Decide completion, the result and any table write for this cycle.
    always_comb begin
        fin       = 1'b0;
        res_hit   = 1'b0;
        res_full  = 1'b0;
        res_dest  = 1'b0;
        tbl_we    = 1'b0;
        tbl_wdata = '0;
        if (state == ST_CLEAR) begin
            tbl_we = 1'b1;
        end else if (state == ST_PROBE) begin
            unique case (op_q)
                OP_ADD: begin
                    fin      = empty || match || last;
                    res_hit  = empty || match;
                    res_full = !(empty || match);
                    tbl_we   = empty || match;
                    tbl_wdata = {{PAD{1'b0}}, key_q, dest_q, skip_q, 1'b1};
                end
                OP_DELETE: begin
                    fin     = empty || match || last;
                    res_hit = match;
                    tbl_we  = match;
                end
                default: begin
                    fin      = empty || match || last;
                    res_hit  = match && !rd_data[SKIP_B];
                    res_dest = match && !rd_data[SKIP_B] && rd_data[DEST_B];
                end
            endcase
        end
    end

    assign tbl_addr = ptr;
    assign busy     = (state != ST_IDLE);

    // State, pointer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CLEAR;
            op_q     <= OP_LOOKUP;
            key_q    <= '0;
            skip_q   <= 1'b0;
            dest_q   <= 1'b0;
            ptr      <= '0;
            hops     <= '0;
            done     <= 1'b0;
            hit      <= 1'b0;
            hit_dest <= 1'b0;
            full     <= 1'b0;
            slot     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_CLEAR: begin
                    ptr <= ptr + 1'b1;
                    if (ptr == {IDX_W{1'b1}}) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        key_q  <= req_mac;
                        skip_q <= req_skip;
                        dest_q <= req_dest;
                        ptr    <= home_idx;
                        hops   <= '0;
                        state  <= ST_PROBE;
                    end
                end
                default: begin
                    if (fin) begin
                        done     <= 1'b1;
                        hit      <= res_hit;
                        hit_dest <= res_dest;
                        full     <= res_full;
                        slot     <= ptr;
                        state    <= ST_IDLE;
                    end else begin
                        ptr  <= ptr + 1'b1;
                        hops <= hops + 1'b1;
                    end
                end
            endcase
        end
    end

    // R11: completion is a single-cycle pulse.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1: no completion while the table is being swept.
    assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |-> !done);
    // R8: the probe never examines more than HOPS entries.
    assert_hop_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE) |-> (hops < HW'(HOPS)));
    // R8: a full report only ends a failed add.
    assert_full_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full) |-> (op_q == OP_ADD && !hit));
    // R7: consecutive probes step by one, wrapping at the table end.
    assert_probe_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE && $past(state) == ST_PROBE) |-> (ptr == $past(ptr) + IDX_W'(1)));
    // R10: the latched request is not disturbed while busy.
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE) |=> $stable(key_q));
endmodule

// File: rtl/mac_hash_filter.sv
// Module: mac_hash_filter (top)
// Destination-address filter: hash unit, entry store and prober.
// Assumes: ENTRY_W leaves room for the address above three flag bits.
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int HOPS    = 12,
    parameter int ENTRY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [47:0]      req_mac,
    input  logic             req_skip,
    input  logic             req_dest,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic             hit_dest,
    output logic             full,
    output logic [10:0]      slot
);
    logic [IDX_W-1:0]   home_idx;
    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_addr;
    logic [ENTRY_W-1:0] tbl_wdata, tbl_rdata;

    mhf_hash u_hash (
        .key_lo    (req_mac[31:0]),
        .key_hi_bit(req_mac[39]),
        .home_idx  (home_idx)
    );

    mhf_table #(.ENTRY_W(ENTRY_W)) u_table (
        .clk  (clk),
        .we   (tbl_we),
        .addr (tbl_addr),
        .wdata(tbl_wdata),
        .rdata(tbl_rdata)
    );

    mhf_ctrl #(.HOPS(HOPS), .ENTRY_W(ENTRY_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_mac  (req_mac),
        .req_skip (req_skip),
        .req_dest (req_dest),
        .home_idx (home_idx),
        .rd_data  (tbl_rdata),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_wdata(tbl_wdata),
        .busy     (busy),
        .done     (done),
        .hit      (hit),
        .hit_dest (hit_dest),
        .full     (full),
        .slot     (slot)
    );
endmodule

// File: tb/mac_hash_filter_bench.sv
module mac_hash_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOPS = 12;
    localparam int DEPTH = 2048;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_skip = 1'b0, req_dest = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [47:0] req_mac = '0;
    logic busy, done, hit, hit_dest, full;
    logic [10:0] slot;

    int checks = 0, errors = 0, cycles = 0;

    mac_hash_filter u_mac_hash_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mac(req_mac), .req_skip(req_skip), .req_dest(req_dest),
        .busy(busy), .done(done), .hit(hit), .hit_dest(hit_dest),
        .full(full), .slot(slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference index from the R2 definition.
    function automatic logic [10:0] ref_hash(input logic [47:0] m);
        logic [31:0] l;
        logic [15:0] h;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++) l[8*b+i] = m[8*b+7-i];
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) h[8*b+i] = m[32+8*b+7-i];
        return {l[3:2], {l[14:8], l[1:0]} ^ l[23:15] ^ {h[0], l[31:24]}};
    endfunction

    // Reference table model.
    bit mv [DEPTH];
    logic [47:0] mm [DEPTH];
    bit ms [DEPTH], md [DEPTH];
    logic m_hit, m_dest, m_full;
    int m_slot, m_probes;

    task automatic m_op(input logic [1:0] op, input logic [47:0] mac, input logic sk, input logic ds);
        int base, i;
        bit mt;
        base = ref_hash(mac);
        m_hit = 0; m_dest = 0; m_full = 0;
        for (int p = 0; p < HOPS; p++) begin
            i = (base + p) % DEPTH;
            mt = mv[i] && (mm[i] == mac);
            m_slot = i; m_probes = p + 1;
            if (op == 2'd1) begin
                if (!mv[i] || mt) begin
                    mv[i] = 1; mm[i] = mac; ms[i] = sk; md[i] = ds; m_hit = 1; return;
                end
            end else if (op == 2'd2) begin
                if (mt) begin mv[i] = 0; mm[i] = '0; m_hit = 1; return; end
                if (!mv[i]) return;
            end else begin
                if (mt) begin m_hit = !ms[i]; m_dest = !ms[i] && md[i]; return; end
                if (!mv[i]) return;
            end
        end
        m_full = (op == 2'd1);
    endtask

    logic r_hit, r_dest, r_full;
    int r_slot, r_cyc;

    task automatic run_op(input logic [1:0] op, input logic [47:0] mac, input logic sk, input logic ds);
        @(negedge clk);
        req_valid = 1; req_op = op; req_mac = mac; req_skip = sk; req_dest = ds;
        r_cyc = 0;
        do begin
            @(posedge clk); #1; r_cyc++;
            if (r_cyc == 1) req_valid = 0;
        end while (!done && r_cyc < 64);
        if (!done) cmp("R11", "no completion", 0, 1);
        r_hit = hit; r_dest = hit_dest; r_full = full; r_slot = slot;
        m_op(op, mac, sk, ds);
    endtask

    task automatic cmp_model(input string req);
        cmp(req, "hit", r_hit, m_hit);
        cmp(req, "dest", r_dest, m_dest);
        cmp(req, "full", r_full, m_full);
        cmp(req, "slot", r_slot, m_slot);
        cmp("R11", "latency", r_cyc, m_probes + 1);
    endtask

    // {op, mac, skip, dest, exp_hit, exp_dest, exp_full}
    localparam logic [54:0] VEC [14] = '{
        {2'd0, 48'h0050C2123400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 48'h0050C2123400, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd0, 48'h0050C2123400, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd1, 48'h0A0B0C0D0E10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd0, 48'h0A0B0C0D0E10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 48'h112233445520, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 48'h112233445520, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 48'h0050C2123400, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 48'h0050C2123400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd2, 48'h0050C2123400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 48'h0A0B0C0D0E10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd0, 48'h0A0B0C0D0E10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd2, 48'h0A0B0C0D0E10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 48'h112233445520, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
    };
    localparam string VREQ [14] = '{"R2", "R6", "R3", "R6", "R4", "R6", "R3",
                                    "R9", "R5", "R9", "R6", "R3", "R9", "R9"};

    function automatic logic [47:0] col(input int k);
        return {8'(k), 8'h80, 32'hFF000030};
    endfunction

    initial begin
        int n, dn;
        logic h0;
        // R1: reset state and clearing sweep.
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        cmp("R1", "busy after reset", busy, 1);
        cmp("R1", "done after reset", done, 0);
        n = 0; dn = 0;
        while (busy && n < 5000) begin
            @(posedge clk); #1; n++;
            if (done) dn++;
        end
        cmp("R1", "clear cycles", n, 2048);
        cmp("R1", "done during clear", dn, 0);

        // Vector walk.
        for (int v = 0; v < 14; v++) begin
            run_op(VEC[v][54:53], VEC[v][52:5], VEC[v][4], VEC[v][3]);
            cmp(VREQ[v], "vec hit", r_hit, VEC[v][2]);
            cmp(VREQ[v], "vec dest", r_dest, VEC[v][1]);
            cmp(VREQ[v], "vec full", r_full, VEC[v][0]);
            cmp_model(VREQ[v]);
        end

        // R2: hash of the collision group lands on the last index.
        run_op(2'd0, col(1), 0, 0);
        cmp("R2", "home index", r_slot, 2047);
        cmp("R1", "empty miss", r_hit, 0);

        // R6/R7: fill the window from 2047, wrapping to 0.
        for (int k = 1; k <= HOPS; k++) begin
            run_op(2'd1, col(k), 0, k[0]);
            cmp("R6", "add placed", r_hit, 1);
            cmp("R7", "add slot", r_slot, (2046 + k) % 2048);
            cmp_model("R6");
        end

        // R8: window full.
        run_op(2'd1, col(13), 0, 0);
        cmp("R8", "full", r_full, 1);
        cmp("R8", "hit", r_hit, 0);
        cmp("R8", "latency", r_cyc, HOPS + 1);
        run_op(2'd0, col(13), 0, 0);
        cmp("R8", "table unchanged", r_hit, 0);
        cmp_model("R5");
        run_op(2'd0, col(12), 0, 0);
        cmp("R5", "last in window", r_slot, 10);
        cmp_model("R3");

        // R10: request while busy is dropped.
        @(negedge clk);
        req_valid = 1; req_op = 2'd0; req_mac = col(12);
        @(posedge clk); #1; req_valid = 0;
        @(negedge clk); req_valid = 1; req_op = 2'd1; req_mac = 48'h00AA00BB00CC;
        @(posedge clk); #1; req_valid = 0;
        n = 2; dn = 0;
        while (n < 30) begin @(posedge clk); #1; n++; if (done) dn++; end
        cmp("R10", "completions", dn, 1);
        run_op(2'd0, 48'h00AA00BB00CC, 0, 0);
        cmp("R10", "dropped add absent", r_hit, 0);
        cmp_model("R10");

        // R11: next request issued in the done cycle; result held.
        run_op(2'd0, col(2), 0, 0);
        cmp_model("R3");
        h0 = r_dest;
        req_valid = 1; req_op = 2'd0; req_mac = col(3);
        @(posedge clk); #1; req_valid = 0;
        cmp("R11", "pulse ends", done, 0);
        cmp("R11", "dest held", hit_dest, h0);
        n = 1;
        while (!done && n < 64) begin @(posedge clk); #1; n++; end
        cmp("R11", "back to back latency", n, 4);
        cmp("R3", "second result", hit_dest, 1);
        m_op(2'd0, col(3), 0, 0);
        repeat (3) @(posedge clk); #1;
        cmp("R11", "hit held", hit, 1);

        // R9/R5: delete the head, then the chain breaks.
        run_op(2'd2, col(1), 0, 0);
        cmp("R9", "delete", r_hit, 1);
        cmp_model("R9");
        run_op(2'd0, col(5), 0, 0);
        cmp("R5", "stop at invalid", r_hit, 0);
        cmp("R5", "early latency", r_cyc, 2);
        cmp_model("R5");
        run_op(2'd1, col(5), 0, 1);
        cmp("R6", "first free wins", r_slot, 2047);
        cmp_model("R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule